// File: doc/BRIEF.md
# Pushbutton Press Pulse Conditioner

This block takes the raw level of a mechanical pushbutton and turns it into a clean enable that lasts one clock cycle, once for each press. The input may change at any moment relative to the clock, and it may chatter for a while after the contacts close or open. One right-shifting sample register handles all three tasks. It registers the raw level on every clock, which gives the first synchronizing stage. A small decoder then watches the stored history and fires only on one exact shape.

That shape is a single low sample in the oldest position with a run of high samples in all the newer positions. A press therefore produces its pulse once the button has been seen high for N-1 consecutive clocks after a low. If the button is still held one clock later, the history becomes all ones and the pulse ends. Chatter that never stays high for N-1 clocks produces nothing. The history length N is a parameter and is chosen to exceed the expected bounce time in clock cycles.

Top module: `btn_press_pulse`

## Requirements
- R1: While `rst` is high on a rising clock edge, the sample history is cleared to all zeros. `press_pulse` is 0 during reset and stays 0 on the first cycle after reset.
- R2: On each rising edge with `rst` low, the sampled `btn_raw` enters the history at the newest end (bit N-1), and every older sample moves one place toward bit 0.
- R3: `press_pulse` is 1 exactly when bits N-1 down to 1 of the history are all 1 and bit 0 is 0. In other words, the last N-1 samples were high and the one before them was low. With N=3 this is the history value 3'b110.
- R4: A pulse lasts exactly one clock cycle. If the button stays high, the history becomes all ones and `press_pulse` returns to 0, so a press held for any length gives one pulse.
- R5: A high run of fewer than N-1 consecutive samples produces no pulse.
- R6: Every fresh run of at least N-1 consecutive high samples that follows a low sample produces exactly one pulse. That pulse appears on the cycle after the edge that captured the (N-1)th high sample.
- R7: Releasing the button produces no pulse, including a release that bounces with high runs shorter than N-1.
- R8: Because reset clears the history to zeros, a button held through a reset counts as a fresh press. A pulse follows after N-1 further high samples once reset has ended.
- R9: The history length N (at least 2) sets the run length that fires. The same input pattern can give a pulse with one N and none with a longer N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset; clears the history |
| btn_raw | input | 1 | Raw, asynchronous, possibly bouncing button level (1 = pressed) |
| press_pulse | output | 1 | One-cycle enable, high once per qualifying press |

## Verification
Two copies are driven in parallel, with history lengths 4 and 3. A sweep applies every 10-sample button sequence after a reset, and each cycle's output is compared with a run-length count kept in the bench. That sweep separates exact-run detection from detecting too early or too late, and it shows whether a long hold gives one pulse or several. Hand-made waveforms then cover a press that bounces and then settles, and a release that bounces. The bounce pattern is chosen so that the length-3 copy must fire twice where the length-4 copy fires once. A reset applied while the button is held shows that held state counts as a new press once reset ends.

// File: rtl/btn_cond_pkg.sv
package btn_cond_pkg;

    // Classification of the sample history held by the conditioner.
    typedef enum logic [1:0] {
        HIST_IDLE   = 2'd0,  // every sample low
        HIST_RISING = 2'd1,  // oldest low, all newer high: the press pattern
        HIST_HELD   = 2'd2,  // every sample high
        HIST_OTHER  = 2'd3   // anything else (bounce in progress)
    } hist_class_e;

    // Smallest history length that can carry one low and one high sample.
    localparam int unsigned MIN_TAPS = 2;

    // Pick a class from the decoded flags.
    function automatic hist_class_e classify(input logic is_idle,
                                             input logic is_rising,
                                             input logic is_held);
        hist_class_e c;
        if (is_rising)      c = HIST_RISING;
        else if (is_held)   c = HIST_HELD;
        else if (is_idle)   c = HIST_IDLE;
        else                c = HIST_OTHER;
        return c;
    endfunction

endpackage

// File: rtl/btn_sample_shreg.sv
module btn_sample_shreg #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sample_in,
    output logic [N-1:0] history
);
    // Newest sample enters at the top bit; older ones move toward bit 0.
    logic [N-1:0] hist_q;
    logic [N-1:0] hist_d;

    always_comb begin
        hist_d = {sample_in, hist_q[N-1:1]};
    end

    always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= hist_d;
    end

    assign history = hist_q;
endmodule

// File: rtl/btn_pattern_decode.sv
module btn_pattern_decode
    import btn_cond_pkg::*;
#(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] history,
    output hist_class_e  hist_class
);
    // Per-bit match against the press pattern: bit 0 low, the rest high.
    logic [N-1:0] match;

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_match
            if (gi == 0) begin : g_oldest
                assign match[gi] = ~history[gi];
            end else begin : g_newer
                assign match[gi] = history[gi];
            end
        end
    endgenerate

    logic is_rising, is_held, is_idle;
    assign is_rising = &match;
    assign is_held   = &history;
    assign is_idle   = ~|history;

    assign hist_class = classify(is_idle, is_rising, is_held);
endmodule

// File: rtl/btn_press_pulse.sv
module btn_press_pulse
    import btn_cond_pkg::*;
#(
    parameter int unsigned N = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_raw,
    output logic press_pulse
);
    localparam int unsigned TAPS = (N < MIN_TAPS) ? MIN_TAPS : N;

    logic [TAPS-1:0] history;
    hist_class_e     hist_class;

    btn_sample_shreg #(.N(TAPS)) u_shreg (
        .clk       (clk),
        .rst       (rst),
        .sample_in (btn_raw),
        .history   (history)
    );

    btn_pattern_decode #(.N(TAPS)) u_decode (
        .history    (history),
        .hist_class (hist_class)
    );

    // Decoded only from registered history, so one clean cycle per match.
    assign press_pulse = (hist_class == HIST_RISING);
endmodule

// File: rtl/btn_press_pulse_chk.sv
module btn_press_pulse_chk #(
    parameter int unsigned N = 4
) (
    input logic clk,
    input logic rst,
    input logic btn_raw,
    input logic press_pulse
);
    localparam int unsigned RW = $clog2(N + 1) + 1;

    // Consecutive-high run length of captured samples, saturating at N.
    logic [RW-1:0] run_q;
    always_ff @(posedge clk) begin
        if (rst)          run_q <= '0;
        else if (!btn_raw) run_q <= '0;
        else if (run_q < RW'(N)) run_q <= run_q + 1'b1;
    end

    // R1: first cycle out of reset is quiet
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !press_pulse);

    // R4: never two cycles in a row
    a_r4_single_cycle: assert property (@(posedge clk) disable iff (rst)
        press_pulse |=> !press_pulse);

    // R7: a low captured sample leaves the output low
    a_r7_low_sample_quiet: assert property (@(posedge clk) disable iff (rst)
        !$past(btn_raw) |-> !press_pulse);

    // R5 / R6: pulse exactly when the run just reached N-1
    a_r6_fresh_run_fires: assert property (@(posedge clk) disable iff (rst)
        press_pulse == (run_q == RW'(N - 1)));
endmodule

bind btn_press_pulse btn_press_pulse_chk #(.N(N)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .btn_raw     (btn_raw),
    .press_pulse (press_pulse)
);

// File: tb/test_btn_press_pulse.sv
module test_btn_press_pulse;
    localparam int CLK_PERIOD = 10;
    localparam int NA = 4;
    localparam int NB = 3;
    localparam int SWEEP_LEN = 10;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic btn_raw = 1'b0;
    logic pulse_a, pulse_b;

    int vectors = 0;
    int fails = 0;
    int run_a = 0;
    int run_b = 0;
    int cnt_a = 0;
    int cnt_b = 0;
    int cycles = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    btn_press_pulse #(.N(NA)) i_btn_press_pulse (
        .clk(clk), .rst(rst), .btn_raw(btn_raw), .press_pulse(pulse_a));
    btn_press_pulse #(.N(NB)) i_btn_press_pulse_n3 (
        .clk(clk), .rst(rst), .btn_raw(btn_raw), .press_pulse(pulse_b));

    function automatic int next_run(int run, int n, logic b, logic r);
        if (r || !b) return 0;
        return (run < n) ? run + 1 : run;
    endfunction

    task automatic check_bit(input logic act, input logic exp, input string tag);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: press_pulse=%0b expected %0b at t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_int(input int act, input int exp, input string tag);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: count=%0d expected %0d", tag, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, compare just after the rising edge.
    task automatic step(input logic b, input logic r, input string tag);
        @(negedge clk);
        btn_raw = b;
        rst = r;
        @(posedge clk);
        run_a = next_run(run_a, NA, b, r);
        run_b = next_run(run_b, NB, b, r);
        #1;
        check_bit(pulse_a, (!r && run_a == NA - 1), {tag, " N=4"});
        check_bit(pulse_b, (!r && run_b == NB - 1), {tag, " N=3"});
        if (pulse_a === 1'b1) cnt_a++;
        if (pulse_b === 1'b1) cnt_b++;
    endtask

    task automatic do_reset();
        step(1'b0, 1'b1, "R1 reset");
        step(1'b0, 1'b1, "R1 reset");
        step(1'b0, 1'b0, "R1 after reset");
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            fails++;
            $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [SWEEP_LEN-1:0] seq;
        logic [19:0] bounce;
        logic [5:0] rel;

        do_reset();

        // R2 R3 R5 R6: every 10-sample sequence after reset
        for (int s = 0; s < (1 << SWEEP_LEN); s++) begin
            seq = SWEEP_LEN'(s);
            do_reset();
            for (int k = 0; k < SWEEP_LEN; k++) step(seq[k], 1'b0, "R3 sweep");
        end

        // R4: a long hold gives one pulse only
        do_reset();
        cnt_a = 0; cnt_b = 0;
        for (int k = 0; k < 40; k++) step(1'b1, 1'b0, "R4 hold");
        check_int(cnt_a, 1, "R4 hold pulses N=4");
        check_int(cnt_b, 1, "R4 hold pulses N=3");

        // R5 R6 R9: bouncing press, runs 1,2,1 then settled high.
        // N=4 needs a run of 3: one pulse. N=3 needs a run of 2: two pulses.
        step(1'b0, 1'b0, "R5 low");
        cnt_a = 0; cnt_b = 0;
        bounce = 20'b1111_1111_1111_0100_1101; // applied LSB first
        for (int k = 0; k < 20; k++) step(bounce[k], 1'b0, "R6 bounce");
        check_int(cnt_a, 1, "R9 bounce pulses N=4");
        check_int(cnt_b, 2, "R9 bounce pulses N=3");

        // R7: bouncy release, high runs of 1 only: no pulse on either
        cnt_a = 0; cnt_b = 0;
        rel = 6'b001010; // LSB first: 0,1,0,1,0,0
        for (int k = 0; k < 6; k++) step(rel[k], 1'b0, "R7 release");
        for (int k = 0; k < 5; k++) step(1'b0, 1'b0, "R7 idle");
        check_int(cnt_a, 0, "R7 release pulses N=4");
        check_int(cnt_b, 0, "R7 release pulses N=3");

        // R8: reset while held, then held again: one pulse per copy
        for (int k = 0; k < 6; k++) step(1'b1, 1'b0, "R8 held");
        cnt_a = 0; cnt_b = 0;
        step(1'b1, 1'b1, "R8 reset held");
        for (int k = 0; k < 6; k++) step(1'b1, 1'b0, "R8 held after reset");
        check_int(cnt_a, 1, "R8 pulses N=4");
        check_int(cnt_b, 1, "R8 pulses N=3");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule